// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps coherence state for a small direct-mapped, write-back private cache that sits on a snooping bus with other caches and a shared memory. Each line holds a tag, one data word and one of four states: Modified, Exclusive, Shared or Invalid. Processor reads and writes are served locally when the state allows it. When it does not, the block arbitrates for the bus and issues a read, a read-for-ownership or a writeback.

On the snoop side, the block watches bus transactions from other agents. It drives the wired-OR shared line for reads of blocks it holds. It supplies or flushes data, and it downgrades or invalidates its copy. When a read fill sees the shared line low, the line is placed in Exclusive. A later write to that line then upgrades to Modified without any bus traffic.

Top module: `mesi_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_done_o` and `bus_req_o` are low, and snooped reads to any address see `snp_shared_o` and `snp_flush_o` low.
- R2: A read that hits a line in Modified, Exclusive or Shared state returns the line data with `cpu_done_o` one cycle after acceptance and raises no bus request.
- R3: A read miss requests the bus with command read (code 1) at the requested address. On the grant cycle the line is filled from `bus_data_i` and becomes Shared if `bus_shared_i` is high or Exclusive if it is low. The data is returned with `cpu_done_o` the cycle after the grant.
- R4: A write hitting an Exclusive or Modified line updates the data, leaves the line Modified, completes one cycle after acceptance and raises no bus request.
- R5: A write that misses or hits a Shared line issues read-for-ownership (code 2) at the requested address and leaves the line Modified with the written data; `cpu_done_o` follows the grant by one cycle.
- R6: A miss whose victim line is Modified first issues a writeback (code 3) carrying the victim's address and data, then the read or read-for-ownership. A victim in Exclusive or Shared state is replaced without a writeback.
- R7: In a snoop cycle with command read, `snp_shared_o` is high exactly when the line holds a valid copy of `snp_addr_i`. In that case `snp_data_o` carries the line data in the same cycle and the line becomes Shared.
- R8: A snooped read or read-for-ownership that hits a Modified line raises `snp_flush_o` in the same cycle with the line data on `snp_data_o`.
- R9: A snooped read-for-ownership that hits the line leaves it Invalid, so a following snooped read sees `snp_shared_o` low.
- R10: Bus command codes are none 0, read 1, read-for-ownership 2, writeback 3. While `bus_req_o` is high without a grant and no snoop is present, the command and address hold steady.
- R11: No processor request is accepted in a cycle in which `snp_valid_i` is high; a held request completes only once the snoop has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with done |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Bus request |
| bus_cmd_o | output | 2 | Bus command code |
| bus_addr_o | output | ADDR_W | Bus transaction address |
| bus_data_o | output | DATA_W | Writeback data |
| bus_gnt_i | input | 1 | Grant; transaction completes in this cycle |
| bus_data_i | input | DATA_W | Fill data in the grant cycle |
| bus_shared_i | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid_i | input | 1 | Snooped transaction from another agent |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | Contribution to the wired-OR shared line |
| snp_flush_o | output | 1 | Modified data being flushed |
| snp_data_o | output | DATA_W | Data supplied to the bus |

## Verification
Each processor result is due a fixed number of cycles after the edge that accepts the request. A silent hit finishes one cycle after acceptance, a clean miss two cycles after, and a dirty miss three cycles after, with one grant per bus transaction. The bench grants every request in the cycle it appears and counts the cycles until done, so latency, transaction count and command order are compared against values predicted from a line-state model. Snoop responses are combinational, so they are sampled one time step after the snoop is driven, in the same cycle. The state change they cause is checked through later snoops and processor operations.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_WB   = 2'd1,
    C_BUS  = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              c_we_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  line_st_e          c_st_i,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  logic [DATA_W-1:0] c_data_i,
  input  logic              s_we_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  line_st_e          s_st_i
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // controller port wins over snoop port on the same line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i]   <= LS_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (c_we_i && c_idx_i == IDX_W'(i)) begin
        st_q[i]   <= c_st_i;
        tag_q[i]  <= c_tag_i;
        data_q[i] <= c_data_i;
      end else if (s_we_i && s_idx_i == IDX_W'(i)) begin
        st_q[i]   <= s_st_i;
      end
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_we_o,
  output line_st_e          upd_st_o
);
  logic hit, is_rd, is_rdx;

  always_comb begin
    hit      = snp_valid_i && (line_st_i != LS_INV) && (line_tag_i == snp_tag_i);
    is_rd    = (snp_cmd_i == BC_RD);
    is_rdx   = (snp_cmd_i == BC_RDX);
    shared_o = hit && is_rd;
    flush_o  = hit && (is_rd || is_rdx) && (line_st_i == LS_MOD);
    data_o   = (shared_o || flush_o) ? line_data_i : '0;
    upd_we_o = hit && (is_rd || is_rdx);
    upd_st_o = is_rd ? LS_SHR : LS_INV;
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  line_st_e          lk_st_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              wr_we_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output line_st_e          wr_st_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o
);
  ctrl_st_e          st_q, st_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic              idle, accept, hit, fast_hit, fill_done;
  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;

  assign idle     = (st_q == C_IDLE);
  assign cur_addr = idle ? cpu_addr_i : req_addr_q;
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign lk_idx_o = cur_addr[IDX_W-1:0];
  assign hit      = (lk_st_i != LS_INV) && (lk_tag_i == cur_tag);
  assign accept   = idle && cpu_req_i && !done_q && !snp_valid_i;
  assign fast_hit = hit && (!cpu_we_i || lk_st_i == LS_EXC || lk_st_i == LS_MOD);
  assign fill_done = (st_q == C_BUS) && bus_gnt_i;

  always_comb begin
    st_d       = st_q;
    bus_req_o  = 1'b0;
    bus_cmd_o  = BC_NONE;
    bus_addr_o = req_addr_q;
    bus_data_o = req_wdata_q;
    wr_we_o    = 1'b0;
    wr_idx_o   = lk_idx_o;
    wr_st_o    = lk_st_i;
    wr_tag_o   = lk_tag_i;
    wr_data_o  = lk_data_i;
    unique case (st_q)
      C_IDLE: begin
        if (accept) begin
          if (fast_hit) begin
            if (cpu_we_i) begin
              wr_we_o   = 1'b1;
              wr_st_o   = LS_MOD;
              wr_data_o = cpu_wdata_i;
            end
          end else if (!hit && lk_st_i == LS_MOD) begin
            st_d = C_WB;
          end else begin
            st_d = C_BUS;
          end
        end
      end
      C_WB: begin
        // victim may have been downgraded or invalidated by a snoop meanwhile
        if (lk_st_i != LS_MOD) begin
          st_d = C_BUS;
        end else begin
          bus_req_o  = 1'b1;
          bus_cmd_o  = BC_WB;
          bus_addr_o = {lk_tag_i, lk_idx_o};
          bus_data_o = lk_data_i;
          if (bus_gnt_i) begin
            wr_we_o = 1'b1;
            wr_st_o = LS_INV;
            st_d    = C_BUS;
          end
        end
      end
      C_BUS: begin
        bus_req_o = 1'b1;
        bus_cmd_o = req_we_q ? BC_RDX : BC_RD;
        if (bus_gnt_i) begin
          wr_we_o   = 1'b1;
          wr_tag_o  = cur_tag;
          wr_st_o   = req_we_q ? LS_MOD : (bus_shared_i ? LS_SHR : LS_EXC);
          wr_data_o = req_we_q ? req_wdata_q : bus_data_i;
          st_d      = C_IDLE;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= C_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= (accept && fast_hit) || fill_done;
      if (accept) begin
        req_we_q    <= cpu_we_i;
        req_addr_q  <= cpu_addr_i;
        req_wdata_q <= cpu_wdata_i;
      end
      if (accept && fast_hit && !cpu_we_i) rdata_q <= lk_data_i;
      else if (fill_done && !req_we_q)     rdata_q <= bus_data_i;
    end
  end

  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, wr_idx;
  line_st_e          lk_st, wr_st, sn_st, upd_st;
  logic [TAG_W-1:0]  lk_tag, wr_tag, sn_tag;
  logic [DATA_W-1:0] lk_data, wr_data, sn_data;
  logic              wr_we, upd_we;

  mesi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_idx_i  (lk_idx),
    .a_st_o   (lk_st),
    .a_tag_o  (lk_tag),
    .a_data_o (lk_data),
    .b_idx_i  (snp_addr_i[IDX_W-1:0]),
    .b_st_o   (sn_st),
    .b_tag_o  (sn_tag),
    .b_data_o (sn_data),
    .c_we_i   (wr_we),
    .c_idx_i  (wr_idx),
    .c_st_i   (wr_st),
    .c_tag_i  (wr_tag),
    .c_data_i (wr_data),
    .s_we_i   (upd_we),
    .s_idx_i  (snp_addr_i[IDX_W-1:0]),
    .s_st_i   (upd_st)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (snp_cmd_i),
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i   (sn_st),
    .line_tag_i  (sn_tag),
    .line_data_i (sn_data),
    .shared_o    (snp_shared_o),
    .flush_o     (snp_flush_o),
    .data_o      (snp_data_o),
    .upd_we_o    (upd_we),
    .upd_st_o    (upd_st)
  );

  mesi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rdata_o  (cpu_rdata_o),
    .cpu_done_o   (cpu_done_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd_o),
    .bus_addr_o   (bus_addr_o),
    .bus_data_o   (bus_data_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_data_i   (bus_data_i),
    .bus_shared_i (bus_shared_i),
    .snp_valid_i  (snp_valid_i),
    .lk_idx_o     (lk_idx),
    .lk_st_i      (lk_st),
    .lk_tag_i     (lk_tag),
    .lk_data_i    (lk_data),
    .wr_we_o      (wr_we),
    .wr_idx_o     (wr_idx),
    .wr_st_o      (wr_st),
    .wr_tag_o     (wr_tag),
    .wr_data_o    (wr_data)
  );
endmodule

// File: rtl/mesi_cache_chk.sv
module mesi_cache_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_done_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_gnt_i,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic              snp_shared_o,
  input logic              snp_flush_o
);
  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i && !snp_valid_i |=>
      bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)); // R10

  AST_REQ_HAS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_cmd_o != 2'd0); // R10

  AST_SHARED_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_shared_o |-> snp_valid_i && snp_cmd_i == 2'd1); // R7

  AST_FLUSH_ON_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_valid_i && (snp_cmd_i == 2'd1 || snp_cmd_i == 2'd2)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o); // R2

  AST_FILL_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_cmd_o != 2'd3 |=> cpu_done_o); // R3

  AST_SNOOP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && !bus_gnt_i |=> !cpu_done_o); // R11
endmodule

bind mesi_cache mesi_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mesi_cache_test.sv
`timescale 1ns/1ps
module mesi_cache_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NL = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          cpu_done;
  logic          bus_req, bus_gnt, bus_shared;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_shared, snp_flush;
  logic [DW-1:0] snp_data;

  mesi_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_done_o(cpu_done),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_data_o(bus_dout), .bus_gnt_i(bus_gnt), .bus_data_i(bus_din),
    .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_data_o(snp_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // model: 0 I, 1 S, 2 E, 3 M
  int            mst [NL];
  logic [1:0]    mtag[NL];
  logic [DW-1:0] mdat[NL];
  logic [DW-1:0] mem [16];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cpu_op(input bit we, input logic [3:0] a, input logic [DW-1:0] wd, input bit sh);
    int idx, cyc, ntx, k, exp_cyc, exp_ntx;
    bit hit, silent, wb, tout;
    string t;
    int            cmd_l [4];
    logic [AW-1:0] addr_l[4];
    logic [DW-1:0] data_l[4];
    logic [DW-1:0] rd;
    idx    = int'(a[1:0]);
    hit    = (mst[idx] != 0) && (mtag[idx] == a[3:2]);
    silent = hit && (!we || mst[idx] >= 2);
    wb     = !hit && (mst[idx] == 3);
    exp_cyc = silent ? 1 : (wb ? 3 : 2);
    exp_ntx = silent ? 0 : (wb ? 2 : 1);
    if (!we) t = hit ? "R2" : "R3";
    else     t = silent ? "R4" : "R5";
    if (!hit && mst[idx] != 0) t = "R6";
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; ntx = 0; tout = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpu_done) break;
      if (bus_req) begin
        if (ntx < 4) begin
          cmd_l[ntx] = int'(bus_cmd); addr_l[ntx] = bus_addr; data_l[ntx] = bus_dout;
        end
        ntx++;
        bus_gnt = 1'b1;
        bus_din = mem[bus_addr];
        bus_shared = sh;
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_dout;
      end else begin
        bus_gnt = 1'b0;
      end
      if (cyc > 20) begin tout = 1'b1; break; end
    end
    rd = cpu_rdata;
    cpu_req = 1'b0; bus_gnt = 1'b0; bus_shared = 1'b0;
    if (tout) chk({t, " timeout"}, 32'd1, 32'd0);
    chk({t, " cycles"}, cyc, exp_cyc);
    chk({t, " transactions"}, ntx, exp_ntx);
    if (!tout && ntx == exp_ntx) begin
      if (wb) begin
        chk("R6 wb cmd", cmd_l[0], 3);
        chk("R6 wb addr", {28'd0, addr_l[0]}, {28'd0, mtag[idx], a[1:0]});
        chk("R6 wb data", {16'd0, data_l[0]}, {16'd0, mdat[idx]});
      end
      if (!silent) begin
        k = wb ? 1 : 0;
        chk("R10 cmd", cmd_l[k], we ? 2 : 1);
        chk({t, " addr"}, {28'd0, addr_l[k]}, {28'd0, a});
      end
    end
    if (!we) chk({t, " rdata"}, {16'd0, rd}, {16'd0, hit ? mdat[idx] : mem[a]});
    if (we) begin
      mst[idx] = 3; mtag[idx] = a[3:2]; mdat[idx] = wd;
    end else if (!hit) begin
      mst[idx] = sh ? 1 : 2; mtag[idx] = a[3:2]; mdat[idx] = mem[a];
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [3:0] a, input string tg);
    int idx;
    bit hit, e_sh, e_fl;
    idx  = int'(a[1:0]);
    hit  = (mst[idx] != 0) && (mtag[idx] == a[3:2]);
    e_sh = hit && (cmd == 2'd1);
    e_fl = hit && (mst[idx] == 3) && (cmd == 2'd1 || cmd == 2'd2);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1;
    chk({tg, " R7 shared"}, {31'd0, snp_shared}, {31'd0, e_sh});
    chk({tg, " R8 flush"}, {31'd0, snp_flush}, {31'd0, e_fl});
    if (e_sh || e_fl) chk({tg, " R7 R8 data"}, {16'd0, snp_data}, {16'd0, mdat[idx]});
    if (e_fl) mem[a] = mdat[idx];
    if (hit && cmd == 2'd1) mst[idx] = 1;
    if (hit && cmd == 2'd2) mst[idx] = 0;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [15:0] lf;
    int sel;
    rst_n = 1'b0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_din = '0; bus_shared = 0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtag[i] = '0; mdat[i] = '0; end
    for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h1357 + 16'h00a5);
    repeat (3) @(negedge clk);
    chk("R1 done", {31'd0, cpu_done}, 32'd0);
    chk("R1 req", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) snoop(2'd1, 4'(i), "R1");

    // Exclusive fill, silent upgrade, flush on snooped read
    cpu_op(1'b0, 4'h5, '0, 1'b0);       // R3 fill to E
    cpu_op(1'b1, 4'h5, 16'hbeef, 1'b0); // R4 silent
    snoop(2'd1, 4'h5, "R8");            // M -> S with flush
    cpu_op(1'b0, 4'h5, '0, 1'b0);       // R2 hit in S
    cpu_op(1'b1, 4'h5, 16'h1234, 1'b0); // R5 upgrade
    cpu_op(1'b1, 4'h9, 16'h4321, 1'b0); // R6 dirty victim
    snoop(2'd2, 4'h9, "R9");
    snoop(2'd1, 4'h9, "R9");
    cpu_op(1'b0, 4'h2, '0, 1'b1);       // R3 fill to S
    cpu_op(1'b0, 4'h6, '0, 1'b0);       // R6 clean victim

    // R11: held hit while a non-hitting snoop is on the bus
    cpu_op(1'b0, 4'h1, '0, 1'b0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'h1;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 4'hd;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 blocked", {31'd0, cpu_done}, 32'd0);
    end
    snp_valid = 1'b0; snp_cmd = 2'd0;
    @(negedge clk);
    chk("R11 resumes", {31'd0, cpu_done}, 32'd1);
    chk("R11 R2 data", {16'd0, cpu_rdata}, {16'd0, mdat[1]});
    cpu_req = 1'b0;
    @(negedge clk);

    lf = 16'hace1;
    for (int n = 0; n < 800; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel = int'(lf[2:0]);
      if (sel < 3)       cpu_op(1'b0, lf[7:4], '0, lf[8]);
      else if (sel < 6)  cpu_op(1'b1, lf[7:4], lf ^ 16'h5a5a, lf[8]);
      else if (sel == 6) snoop(2'd1, lf[7:4], "R7");
      else begin
        snoop(2'd2, lf[7:4], "R8");
        snoop(2'd1, lf[7:4], "R9");
      end
    end
    summary();
  end
endmodule